// File: doc/BRIEF.md
# Blowfish Block Cipher Core

This core enciphers or deciphers one 64-bit block with the sixteen-round Blowfish Feistel network. The key-dependent state is eighteen 32-bit round keys and four substitution tables of 256 words each. The host must load all of it through a word-wide write port before it sends any data. The key schedule itself is computed by the host. The core only stores the result and uses it.

Blocks arrive on a 64-bit valid/ready input channel together with a direction flag. The core runs one round per clock and then spends one clock on output whitening. The result is held on a 64-bit valid/ready output channel until it is taken. The core accepts a new block only after that.

A batch flag groups consecutive blocks into runs of four. During a batch, chained deciphering XORs each result after the first of the run with the ciphertext that preceded it. This gives the chaining step of cipher-block-chaining decryption inside the group.

Top module: `bf_core`

## Requirements
- R1: A block is split big-endian: bits 63:32 form the left half and bits 31:0 the right half, and the output uses the same layout. Enciphering runs 16 rounds. In round i the left half is XORed with round key i, the round function of that value is XORed into the right half, and the halves swap. The round function of bytes a (bits 31:24), b, c, d returns ((T0[a] + T1[b]) XOR T2[c]) + T3[d], modulo 2^32. After the last round the swap is undone, and round key 16 is XORed into the right half and key 17 into the left half.
- R2: Deciphering uses the same network with round keys 17 down to 2 in the rounds, then key 1 on the right half and key 0 on the left half. It inverts enciphering.
- R3: The output becomes valid exactly 17 clock cycles after the cycle in which the input was accepted. in_ready stays low from acceptance until the output has been taken.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R5: The key write port uses key_sel 0 to 3 for tables T0 to T3, indexed 0 to 255, and key_sel 4 for the round keys, indexed 0 to 17. key_ok is high exactly when a write is taken. A write presented while a block is in flight is refused and leaves the key state unchanged.
- R6: When batch, chain and decipher are all set, the results of batch positions 1, 2 and 3 are XORed with the input block of the preceding position. The result of position 0 is not XORed.
- R7: A batch block with chain low, or any enciphered block, receives no XOR.
- R8: The batch position advances by one per accepted batch block and wraps from 3 back to 0. A block accepted with batch low returns the position to 0.
- R9: A synchronous active-low reset drops any pending output and any block in flight. The key state is kept.
- R10: After reset, out_valid is low and in_ready is high. in_ready and out_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_we | input | 1 | Key write request |
| key_sel | input | 3 | Key memory: 0-3 tables, 4 round keys |
| key_idx | input | 8 | Entry index |
| key_wdata | input | 32 | Entry value |
| key_ok | output | 1 | Write taken this cycle |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Core can take a block |
| in_data | input | 64 | Input block |
| in_decipher | input | 1 | 1 deciphers, 0 enciphers |
| in_batch | input | 1 | Block belongs to a four-block batch |
| in_chain | input | 1 | Apply chaining XOR in the batch |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result block |

## Verification
The hardest case to reach from the ports is the batch-position state. The chaining XOR depends on the position within a four-block run and on the ciphertext of the block before it, and neither is visible at the ports. The bench drives a run of five chained batch deciphers, then a non-batch block, then a further batch block. This covers position 0, the XORed positions, the wrap back to 0 and the reset by a non-batch block, and each result is compared with an arithmetic model. A key write is also attempted in the middle of a block. The effect of that write is then looked for in the next enciphered result.

// File: rtl/bf_pkg.sv
// Shared constants and types for the Blowfish core.
// Assumes a 32-bit half word and 8-bit table indices.
package bf_pkg;
    localparam int HALF_W   = 32;
    localparam int BLK_W    = 2 * HALF_W;
    localparam int SB_AW    = 8;
    localparam int NSB      = 4;
    localparam int NSUB     = 18;
    localparam int NROUND   = 16;
    localparam int SEL_W    = 3;
    localparam logic [SEL_W-1:0] SEL_SUBKEY = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} bf_state_t;
endpackage

// File: rtl/bf_keystore.sv
// Key storage: NSB substitution tables and NSUB round keys.
// Reads are combinational. A write is taken when wr_en is high.
// Gating writes against busy is the caller's job. No reset: the contents survive rst_n.
module bf_keystore #(
    parameter int W     = bf_pkg::HALF_W,
    parameter int AW    = bf_pkg::SB_AW,
    parameter int NT    = bf_pkg::NSB,
    parameter int NK    = bf_pkg::NSUB,
    parameter int SW    = bf_pkg::SEL_W,
    localparam int PW   = $clog2(NK)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_sel,
    input  logic [AW-1:0]   wr_idx,
    input  logic [W-1:0]    wr_data,
    input  logic [NT*AW-1:0] sb_idx,
    output logic [NT*W-1:0]  sb_val,
    input  logic [PW-1:0]   pk_a,
    input  logic [PW-1:0]   pk_b,
    output logic [W-1:0]    pk_va,
    output logic [W-1:0]    pk_vb
);
    logic [W-1:0] pk_mem [NK];

    for (genvar t = 0; t < NT; t++) begin : g_tbl
        logic [W-1:0] mem [2**AW];
        // table write
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == SW'(t))
                mem[wr_idx] <= wr_data;
        end
        assign sb_val[t*W +: W] = mem[sb_idx[t*AW +: AW]];
    end

    // round-key write, out-of-range indices dropped
    always_ff @(posedge clk) begin
        if (wr_en && wr_sel == bf_pkg::SEL_SUBKEY && int'(wr_idx) < NK)
            pk_mem[wr_idx[PW-1:0]] <= wr_data;
    end

    assign pk_va = pk_mem[pk_a];
    assign pk_vb = pk_mem[pk_b];
endmodule

// File: rtl/bf_round.sv
// One combinational Feistel round: whiten the left half with the key,
// look up its four bytes, mix the four lookups, fold into the right half, swap.
// The table lookups are done outside, through sb_idx and sb_val.
module bf_round #(
    parameter int W  = bf_pkg::HALF_W,
    parameter int AW = bf_pkg::SB_AW,
    localparam int NT = W / AW
) (
    input  logic [W-1:0]     l_in,
    input  logic [W-1:0]     r_in,
    input  logic [W-1:0]     rkey,
    output logic [NT*AW-1:0] sb_idx,
    input  logic [NT*W-1:0]  sb_val,
    output logic [W-1:0]     l_out,
    output logic [W-1:0]     r_out
);
    logic [W-1:0] x, f;

    // table t is addressed by byte t counted from the most significant end
    assign x = l_in ^ rkey;
    for (genvar t = 0; t < NT; t++) begin : g_idx
        assign sb_idx[t*AW +: AW] = x[W-1-t*AW -: AW];
    end

    // add, xor, add mixing of the four lookups
    always_comb begin
        f = ((sb_val[0 +: W] + sb_val[W +: W]) ^ sb_val[2*W +: W]) + sb_val[3*W +: W];
    end

    assign l_out = r_in ^ f;
    assign r_out = x;
endmodule

// File: rtl/bf_chain.sv
// Batch tracker: keeps the position inside a four-block run and the
// previous input block. On each acceptance it latches the XOR mask the result will need.
module bf_chain #(
    parameter int BW    = bf_pkg::BLK_W,
    parameter int BATCH = 4,
    localparam int PSW  = $clog2(BATCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          batch,
    input  logic          chain,
    input  logic          decipher,
    input  logic [BW-1:0] blk_in,
    output logic [BW-1:0] mask
);
    logic [PSW-1:0] pos;
    logic [BW-1:0]  prev;

    // position counter and previous-block capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            prev <= '0;
            mask <= '0;
        end else if (accept) begin
            prev <= blk_in;
            pos  <= batch ? pos + 1'b1 : '0;
            mask <= (batch && chain && decipher && pos != '0) ? prev : '0;
        end
    end
endmodule

// File: rtl/bf_core.sv
// Blowfish block core: one round per clock, then one whitening clock.
// Assumes the host has loaded all key memories before sending data.
// in_ready is low while a block is in flight or a result is waiting.
module bf_core #(
    parameter int W      = bf_pkg::HALF_W,
    parameter int AW     = bf_pkg::SB_AW,
    parameter int NK     = bf_pkg::NSUB,
    parameter int NROUND = bf_pkg::NROUND,
    parameter int SW     = bf_pkg::SEL_W,
    localparam int BW    = 2 * W,
    localparam int NT    = W / AW,
    localparam int PW    = $clog2(NK),
    localparam int RW    = $clog2(NROUND)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic [SW-1:0] key_sel,
    input  logic [AW-1:0] key_idx,
    input  logic [W-1:0]  key_wdata,
    output logic          key_ok,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [BW-1:0] in_data,
    input  logic          in_decipher,
    input  logic          in_batch,
    input  logic          in_chain,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [BW-1:0] out_data
);
    import bf_pkg::*;

    bf_state_t         state;
    logic [RW-1:0]     rnd;
    logic [W-1:0]      l_q, r_q, l_n, r_n, pk_va, pk_vb;
    logic              dec_q, accept;
    logic [PW-1:0]     pk_a, pk_b;
    logic [NT*AW-1:0]  sb_idx;
    logic [NT*W-1:0]   sb_val;
    logic [BW-1:0]     mask;

    assign in_ready = (state == ST_IDLE) && !out_valid;
    assign accept   = in_valid && in_ready;
    assign key_ok   = key_we && (state == ST_IDLE);

    // key-memory indices: forward or reverse round key, or the whitening pair
    always_comb begin
        if (state == ST_FIN) begin
            pk_a = dec_q ? PW'(0) : PW'(NK - 1);
            pk_b = dec_q ? PW'(1) : PW'(NK - 2);
        end else begin
            pk_a = dec_q ? PW'(NK - 1) - PW'(rnd) : PW'(rnd);
            pk_b = pk_a;
        end
    end

    bf_keystore #(.W(W), .AW(AW), .NT(NT), .NK(NK), .SW(SW)) u_keys (
        .clk(clk), .wr_en(key_ok), .wr_sel(key_sel), .wr_idx(key_idx),
        .wr_data(key_wdata), .sb_idx(sb_idx), .sb_val(sb_val),
        .pk_a(pk_a), .pk_b(pk_b), .pk_va(pk_va), .pk_vb(pk_vb)
    );

    bf_round #(.W(W), .AW(AW)) u_round (
        .l_in(l_q), .r_in(r_q), .rkey(pk_va), .sb_idx(sb_idx),
        .sb_val(sb_val), .l_out(l_n), .r_out(r_n)
    );

    bf_chain #(.BW(BW)) u_chain (
        .clk(clk), .rst_n(rst_n), .accept(accept), .batch(in_batch),
        .chain(in_chain), .decipher(in_decipher), .blk_in(in_data), .mask(mask)
    );

    // control sequence: idle, rounds, whitening, output handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rnd       <= '0;
            out_valid <= 1'b0;
        end else begin
            if (out_valid && out_ready)
                out_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_RUN;
                    rnd   <= '0;
                end
                ST_RUN: begin
                    if (rnd == RW'(NROUND - 1))
                        state <= ST_FIN;
                    rnd <= rnd + 1'b1;
                end
                ST_FIN: begin
                    state     <= ST_IDLE;
                    out_valid <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // datapath: load the halves, step a round, whiten and chain into the output
    always_ff @(posedge clk) begin
        if (accept) begin
            l_q   <= in_data[BW-1:W];
            r_q   <= in_data[W-1:0];
            dec_q <= in_decipher;
        end else if (state == ST_RUN) begin
            l_q <= l_n;
            r_q <= r_n;
        end
        if (state == ST_FIN)
            out_data <= {r_q ^ pk_va, l_q ^ pk_vb} ^ mask;
    end
endmodule

// File: rtl/bf_core_chk.sv
// Protocol checker for bf_core, attached to every instance by bind.
module bf_core_chk #(
    parameter int BW     = 64,
    parameter int NROUND = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          key_we,
    input logic          key_ok,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [BW-1:0] out_data
);
    localparam int CW = $clog2(NROUND + 4) + 1;
    logic [CW-1:0] since_acc;

    // counts clock edges since acceptance, up to and including the edge where out_valid rises
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_acc <= '0;
        else if (in_valid && in_ready)
            since_acc <= CW'(1);
        else if (since_acc != '0 && !out_valid)
            since_acc <= since_acc + 1'b1;
    end

    // R4
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R3
    busy_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> since_acc == CW'(NROUND + 2));
    // R5
    wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we && !in_ready && !out_valid |-> !key_ok);
    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && in_ready);
endmodule

bind bf_core bf_core_chk #(.BW(BW), .NROUND(NROUND)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_ok(key_ok),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_bf_core.sv
// Bench for bf_core: loads generated key material, checks against an arithmetic model.
module tb_bf_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_we = 1'b0;
    logic [2:0]  key_sel = '0;
    logic [7:0]  key_idx = '0;
    logic [31:0] key_wdata = '0;
    logic        key_ok;
    logic        in_valid = 1'b0, in_ready;
    logic [63:0] in_data = '0;
    logic        in_decipher = 1'b0, in_batch = 1'b0, in_chain = 1'b0;
    logic        out_valid, out_ready = 1'b0;
    logic [63:0] out_data;

    bf_core dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int total = 0, fails = 0, cyc = 0, acc_cyc = 0;
    logic [31:0] mp [18];
    logic [31:0] ms [4][256];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] gen_sb(int t, int i);
        logic [31:0] v;
        v = 32'(i) * 32'h045D9F3B + 32'(t) * 32'h7ED55D16 + 32'h1234567;
        v = v ^ (v >> 15) ^ (v << 7);
        return v * 32'h2C1B3C6D;
    endfunction

    function automatic logic [31:0] rf(logic [31:0] x);
        return ((ms[0][x[31:24]] + ms[1][x[23:16]]) ^ ms[2][x[15:8]]) + ms[3][x[7:0]];
    endfunction

    function automatic logic [63:0] model(logic [63:0] b, bit dec);
        logic [31:0] l, r, x;
        l = b[63:32]; r = b[31:0];
        for (int i = 0; i < 16; i++) begin
            x = l ^ mp[dec ? 17 - i : i];
            l = r ^ rf(x);
            r = x;
        end
        return dec ? {r ^ mp[0], l ^ mp[1]} : {r ^ mp[17], l ^ mp[16]};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic kwrite(logic [2:0] s, int i, logic [31:0] d, output bit ok);
        @(negedge clk);
        key_we = 1'b1; key_sel = s; key_idx = 8'(i); key_wdata = d;
        #1 ok = key_ok;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic send(logic [63:0] d, bit dec, bit bat, bit chn);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = d; in_decipher = dec; in_batch = bat; in_chain = chn;
        @(negedge clk);
        acc_cyc = cyc;
        in_valid = 1'b0;
    endtask

    task automatic collect(int hold, output logic [63:0] got, output int lat);
        while (!out_valid) @(negedge clk);
        lat = cyc - acc_cyc;
        got = out_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(out_valid && out_data == got, "R4 hold", out_data, got);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run(logic [63:0] d, bit dec, bit bat, bit chn, logic [63:0] exp, string tag);
        logic [63:0] got; int lat;
        send(d, dec, bat, chn);
        collect(0, got, lat);
        chk(got == exp, tag, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [63:0] got, exp, ct, pt;
        logic [63:0] cb [5];
        int lat;
        bit ok, all_ok;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!out_valid && in_ready, "R10 reset state", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;

        // R5 load all key memories
        all_ok = 1'b1;
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 256; i++) begin
                ms[t][i] = gen_sb(t, i);
                kwrite(3'(t), i, ms[t][i], ok);
                all_ok &= ok;
            end
        for (int k = 0; k < 18; k++) begin
            mp[k] = 32'h243F6A88 + 32'(k) * 32'h13198A2F;
            kwrite(3'd4, k, mp[k], ok);
            all_ok &= ok;
        end
        chk(all_ok, "R5 writes taken when idle", 64'(all_ok), 64'd1);

        // R1 R2 R3 encipher/decipher sweep with latency and round trip
        for (int n = 0; n < 8; n++) begin
            pt = {32'(n) * 32'h9E3779B9, ~(32'(n) << (n * 3))};
            send(pt, 1'b0, 1'b0, 1'b0);
            collect(n % 3, ct, lat);
            chk(ct == model(pt, 1'b0), "R1 encipher", ct, model(pt, 1'b0));
            chk(lat == 17, "R3 latency", 64'(lat), 64'd17);
            send(ct, 1'b1, 1'b0, 1'b0);
            collect(0, got, lat);
            chk(got == pt, "R2 decipher inverts", got, pt);
        end

        // R5 write refused while a block is in flight
        pt = 64'h0123456789ABCDEF;
        send(pt, 1'b0, 1'b0, 1'b0);
        kwrite(3'd4, 0, 32'hDEADBEEF, ok);
        chk(!ok, "R5 busy write refused", 64'(ok), 64'd0);
        kwrite(3'd2, 7, 32'hCAFEF00D, ok);
        chk(!ok, "R5 busy write refused", 64'(ok), 64'd0);
        chk(in_ready == 1'b0, "R3 busy ready low", 64'(in_ready), 64'd0);
        collect(2, got, lat);
        chk(got == model(pt, 1'b0), "R5 key unchanged", got, model(pt, 1'b0));

        // R6 R8 chained batch decipher: five blocks, position wraps
        run(64'h1, 1'b1, 1'b0, 1'b0, model(64'h1, 1'b1), "R2 non-batch");
        for (int i = 0; i < 5; i++) cb[i] = {32'(i + 1) * 32'h11111111, 32'hA5A5A5A5 ^ 32'(i)};
        for (int i = 0; i < 5; i++) begin
            exp = model(cb[i], 1'b1);
            if (i == 1 || i == 2 || i == 3) exp ^= cb[i - 1];
            run(cb[i], 1'b1, 1'b1, 1'b1, exp, (i == 4) ? "R8 wrap to position 0" : "R6 chained batch");
        end
        // R8 non-batch block resets position
        run(cb[0], 1'b1, 1'b1, 1'b1, model(cb[0], 1'b1) ^ cb[4], "R6 position 1 after wrap");
        run(cb[1], 1'b1, 1'b0, 1'b1, model(cb[1], 1'b1), "R8 non-batch no xor");
        run(cb[2], 1'b1, 1'b1, 1'b1, model(cb[2], 1'b1), "R8 reset to position 0");
        run(cb[3], 1'b1, 1'b1, 1'b1, model(cb[3], 1'b1) ^ cb[2], "R6 position 1");

        // R7 chain low or enciphering: no xor
        run(64'h0, 1'b1, 1'b0, 1'b0, model(64'h0, 1'b1), "R7 setup");
        for (int i = 0; i < 4; i++)
            run(cb[i], 1'b1, 1'b1, 1'b0, model(cb[i], 1'b1), "R7 chain off");
        for (int i = 0; i < 4; i++)
            run(cb[i], 1'b0, 1'b1, 1'b1, model(cb[i], 1'b0), "R7 encipher batch");

        // R9 reset mid-block and with a pending result; keys survive
        send(pt, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R9 reset mid block", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;
        send(pt, 1'b0, 1'b0, 1'b0);
        while (!out_valid) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R9 reset drops output", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;
        run(pt, 1'b0, 1'b0, 1'b0, model(pt, 1'b0), "R9 keys kept");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule